// File: doc/BRIEF.md
# Receive Special-Character Control Engine

This block sits between the character decoder of a serial link receiver and the write port of its receive FIFO. Each cycle it may accept one decoded character: an 8-bit value, a flag saying whether the value is a control code or plain data, and a flag saying the decoder saw a code violation. Most characters are written to the FIFO one clock edge later as a word of 8 data bits with start-of-cell, control and violation flags.

Four control codes are treated as in-band signals and are never written. Two of them are markers: they are consumed and change how the next written character is tagged. One marks the start of a cell. The other marks the next character as one of 256 expanded commands. The other two codes drive a single level output high or low. This lets a slow signal cross the link without using FIFO space. A bypass input turns all of this off, and every character is then written exactly as received.

Top module: `rx_special_ctl`

## Requirements
- R1: A valid control character with value 0xF7 (cell marker) is not written. The next written non-violation character keeps its data byte and is written with start-of-cell 1, control 0 and violation 0.
- R2: A valid control character with value 0xFB (command marker) is not written. The next written non-violation character keeps its data byte and is written with start-of-cell 1, control 1 and violation 0.
- R3: A valid control character 0x1C drives `sig_o` to 1 and a valid control character 0x7C drives it to 0, one edge later. Neither is written, and neither changes a pending marker tag.
- R4: A valid character with its violation flag set, whatever its value or control flag, is written with data 0xE0, violation 1, control 1 and start-of-cell 0. It also discards any pending marker tag.
- R5: Any other control value is written unchanged with control 1 and start-of-cell 0. Any data character, including the marker and signal byte values sent with control 0, is written with control 0, start-of-cell 0 and violation 0, unless a tag is pending.
- R6: A marker that arrives while a tag is pending replaces that tag, and no word is written for the earlier marker.
- R7: While `rst_n` is low at a rising edge, the write strobe and `sig_o` go to 0 and any pending tag is cleared.
- R8: The write strobe is high for one cycle per stored character, exactly one edge after a valid input. Cycles with `in_valid` low write nothing and change neither the pending tag nor `sig_o`.
- R9: With `bypass` high, each valid character is written with its data, control and violation flags unchanged and start-of-cell 0. No marker is stripped, `sig_o` holds its value, and any pending tag is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded character present this cycle |
| in_data | input | 8 | Decoded character value |
| in_is_ctrl | input | 1 | 1 for a control code, 0 for data |
| in_viol | input | 1 | Decoder reported a code violation |
| bypass | input | 1 | Pass all characters unmodified |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | Word data byte |
| wr_soc_o | output | 1 | Start-of-cell tag |
| wr_ctrl_o | output | 1 | Control flag of the written word |
| wr_viol_o | output | 1 | Violation flag of the written word |
| sig_o | output | 1 | In-band signal level |

## Verification
Every result of this block is due on the first rising edge after the character is presented. This holds for the written word, for the absence of a strobe after a marker, and for the change on `sig_o`. A marker's effect on tagging shows only in the word for the next valid character. The bench therefore changes inputs on the falling edge and reads outputs on the next falling edge, so each check falls exactly one edge after its stimulus. Tag carry-over is checked on the character that follows, after any intervening signal codes or idle cycles.

// File: rtl/rxce_pkg.sv
package rxce_pkg;

    typedef enum logic [1:0] {
        TAG_NONE,
        TAG_CELL,
        TAG_CMD
    } tag_e;

    typedef enum logic [2:0] {
        CLS_DATA,
        CLS_CTRL,
        CLS_VIOL,
        CLS_CELL,
        CLS_CMD,
        CLS_SIG_HI,
        CLS_SIG_LO,
        CLS_PASS
    } cls_e;

endpackage

// File: rtl/rxce_classify.sv
module rxce_classify
    import rxce_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] CELL_CODE   = 8'hF7,
    parameter logic [DATA_W-1:0] CMD_CODE    = 8'hFB,
    parameter logic [DATA_W-1:0] SIG_HI_CODE = 8'h1C,
    parameter logic [DATA_W-1:0] SIG_LO_CODE = 8'h7C
) (
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_ctrl,
    input  logic              in_viol,
    input  logic              bypass,
    output cls_e              cls
);
    localparam int NUM_MK = 4;
    localparam logic [DATA_W-1:0] MK_CODE [NUM_MK] =
        '{CELL_CODE, CMD_CODE, SIG_HI_CODE, SIG_LO_CODE};

    logic [NUM_MK-1:0] hit;

    for (genvar i = 0; i < NUM_MK; i++) begin : g_match
        assign hit[i] = in_is_ctrl && (in_data == MK_CODE[i]);
    end

    always_comb begin
        if (bypass)          cls = CLS_PASS;
        else if (in_viol)    cls = CLS_VIOL;
        else if (hit[0])     cls = CLS_CELL;
        else if (hit[1])     cls = CLS_CMD;
        else if (hit[2])     cls = CLS_SIG_HI;
        else if (hit[3])     cls = CLS_SIG_LO;
        else if (in_is_ctrl) cls = CLS_CTRL;
        else                 cls = CLS_DATA;
    end
endmodule

// File: rtl/rxce_tag_track.sv
module rxce_tag_track
    import rxce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  cls_e cls,
    output tag_e pend_o
);
    tag_e pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (in_valid) begin
            case (cls)
                CLS_CELL:               pend_d = TAG_CELL;
                CLS_CMD:                pend_d = TAG_CMD;
                CLS_SIG_HI, CLS_SIG_LO: pend_d = pend_q;
                default:                pend_d = TAG_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= TAG_NONE;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R3: signal codes leave the pending tag alone
    p_sig_keeps_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls == CLS_SIG_HI || cls == CLS_SIG_LO)) |=> $stable(pend_q));

    // R8: idle cycles leave the pending tag alone
    p_idle_keeps_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pend_q));

    // R6: a second marker overwrites the first
    p_marker_replaces_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_CMD) |=> (pend_q == TAG_CMD));
endmodule

// File: rtl/rxce_sig_level.sv
module rxce_sig_level
    import rxce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  cls_e cls,
    output logic level_o
);
    logic level_d, level_q;

    always_comb begin
        level_d = level_q;
        if (in_valid && cls == CLS_SIG_HI) level_d = 1'b1;
        if (in_valid && cls == CLS_SIG_LO) level_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_d;
    end

    assign level_o = level_q;

    // R9: anything but a recognised signal code holds the level
    p_level_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (cls == CLS_SIG_HI || cls == CLS_SIG_LO)) |=> $stable(level_q));
endmodule

// File: rtl/rxce_word_form.sv
module rxce_word_form
    import rxce_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] SUBST_CODE = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_ctrl,
    input  logic              in_viol,
    input  cls_e              cls,
    input  tag_e              pend,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_soc_o,
    output logic              wr_ctrl_o,
    output logic              wr_viol_o
);
    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] data;
        logic              soc;
        logic              ctrl;
        logic              viol;
    } word_t;

    word_t w_d, w_q;

    always_comb begin
        w_d    = w_q;
        w_d.wr = 1'b0;
        if (in_valid) begin
            case (cls)
                CLS_PASS: begin
                    w_d.wr   = 1'b1;
                    w_d.data = in_data;
                    w_d.soc  = 1'b0;
                    w_d.ctrl = in_is_ctrl;
                    w_d.viol = in_viol;
                end
                CLS_VIOL: begin
                    w_d.wr   = 1'b1;
                    w_d.data = SUBST_CODE;
                    w_d.soc  = 1'b0;
                    w_d.ctrl = 1'b1;
                    w_d.viol = 1'b1;
                end
                CLS_DATA, CLS_CTRL: begin
                    w_d.wr   = 1'b1;
                    w_d.data = in_data;
                    w_d.viol = 1'b0;
                    case (pend)
                        TAG_CELL: begin
                            w_d.soc  = 1'b1;
                            w_d.ctrl = 1'b0;
                        end
                        TAG_CMD: begin
                            w_d.soc  = 1'b1;
                            w_d.ctrl = 1'b1;
                        end
                        default: begin
                            w_d.soc  = 1'b0;
                            w_d.ctrl = (cls == CLS_CTRL);
                        end
                    endcase
                end
                default: w_d.wr = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wr_en_o   = w_q.wr;
    assign wr_data_o = w_q.data;
    assign wr_soc_o  = w_q.soc;
    assign wr_ctrl_o = w_q.ctrl;
    assign wr_viol_o = w_q.viol;

    // R8: a strobe only ever follows a valid input
    p_strobe_from_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.wr |-> $past(in_valid));

    // R1: a tagged word never carries a violation
    p_soc_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.wr && w_q.soc) |-> !w_q.viol);

    // R4: substituted violation word outside bypass
    p_viol_subst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.wr && w_q.viol && $past(cls != CLS_PASS)) |-> (w_q.ctrl && w_q.data == SUBST_CODE));
endmodule

// File: rtl/rx_special_ctl.sv
module rx_special_ctl
    import rxce_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] CELL_CODE   = 8'hF7,
    parameter logic [DATA_W-1:0] CMD_CODE    = 8'hFB,
    parameter logic [DATA_W-1:0] SIG_HI_CODE = 8'h1C,
    parameter logic [DATA_W-1:0] SIG_LO_CODE = 8'h7C,
    parameter logic [DATA_W-1:0] SUBST_CODE  = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_ctrl,
    input  logic              in_viol,
    input  logic              bypass,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_soc_o,
    output logic              wr_ctrl_o,
    output logic              wr_viol_o,
    output logic              sig_o
);
    cls_e cls;
    tag_e pend;

    rxce_classify #(
        .DATA_W     (DATA_W),
        .CELL_CODE  (CELL_CODE),
        .CMD_CODE   (CMD_CODE),
        .SIG_HI_CODE(SIG_HI_CODE),
        .SIG_LO_CODE(SIG_LO_CODE)
    ) classify_i (
        .in_data   (in_data),
        .in_is_ctrl(in_is_ctrl),
        .in_viol   (in_viol),
        .bypass    (bypass),
        .cls       (cls)
    );

    rxce_tag_track tag_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .cls     (cls),
        .pend_o  (pend)
    );

    rxce_sig_level sig_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .cls     (cls),
        .level_o (sig_o)
    );

    rxce_word_form #(
        .DATA_W    (DATA_W),
        .SUBST_CODE(SUBST_CODE)
    ) word_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_is_ctrl(in_is_ctrl),
        .in_viol   (in_viol),
        .cls       (cls),
        .pend      (pend),
        .wr_en_o   (wr_en_o),
        .wr_data_o (wr_data_o),
        .wr_soc_o  (wr_soc_o),
        .wr_ctrl_o (wr_ctrl_o),
        .wr_viol_o (wr_viol_o)
    );

    // R1: cell marker is consumed
    p_cell_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bypass && !in_viol && in_is_ctrl && in_data == CELL_CODE) |=> !wr_en_o);

    // R2: command marker is consumed
    p_cmd_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bypass && !in_viol && in_is_ctrl && in_data == CMD_CODE) |=> !wr_en_o);

    // R3: signal-high code raises the level without a write
    p_sig_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bypass && !in_viol && in_is_ctrl && in_data == SIG_HI_CODE)
        |=> (sig_o && !wr_en_o));

    // R7: reset clears strobe and level
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!wr_en_o && !sig_o));

    // R9: bypass writes the raw byte untagged
    p_bypass_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bypass) |=> (wr_en_o && wr_data_o == $past(in_data) && !wr_soc_o));
endmodule

// File: tb/rx_special_ctl_tb.sv
module rx_special_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_is_ctrl = 1'b0;
    logic       in_viol = 1'b0;
    logic       bypass = 1'b0;
    logic       wr_en_o, wr_soc_o, wr_ctrl_o, wr_viol_o, sig_o;
    logic [7:0] wr_data_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    rx_special_ctl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_is_ctrl(in_is_ctrl),
        .in_viol   (in_viol),
        .bypass    (bypass),
        .wr_en_o   (wr_en_o),
        .wr_data_o (wr_data_o),
        .wr_soc_o  (wr_soc_o),
        .wr_ctrl_o (wr_ctrl_o),
        .wr_viol_o (wr_viol_o),
        .sig_o     (sig_o)
    );

    // vector: v b c x data[8] | ew es ec ev edata[8] esig | req[4]
    function automatic logic [28:0] mkv(bit v, bit b, bit c, bit x, logic [7:0] d,
                                        bit ew, bit es, bit ec, bit ev, logic [7:0] ed,
                                        bit esig, logic [3:0] r);
        return {v, b, c, x, d, ew, es, ec, ev, ed, esig, r};
    endfunction

    localparam int NV = 34;
    localparam logic [28:0] VEC [NV] = '{
        mkv(1,0,0,0,8'h55, 1,0,0,0,8'h55, 0, 4'd5),  // R5 plain data
        mkv(1,0,1,0,8'hBC, 1,0,1,0,8'hBC, 0, 4'd5),  // R5 other control
        mkv(1,0,1,0,8'hF7, 0,0,0,0,8'h00, 0, 4'd1),  // R1 cell marker dropped
        mkv(1,0,0,0,8'h12, 1,1,0,0,8'h12, 0, 4'd1),  // R1 tagged
        mkv(1,0,0,0,8'h13, 1,0,0,0,8'h13, 0, 4'd1),  // R1 tag used once
        mkv(1,0,1,0,8'hFB, 0,0,0,0,8'h00, 0, 4'd2),  // R2 command marker
        mkv(1,0,0,0,8'h40, 1,1,1,0,8'h40, 0, 4'd2),  // R2 tagged command
        mkv(1,0,1,0,8'h1C, 0,0,0,0,8'h00, 1, 4'd3),  // R3 level high
        mkv(1,0,0,0,8'h99, 1,0,0,0,8'h99, 1, 4'd3),  // R3 level held
        mkv(1,0,1,0,8'h7C, 0,0,0,0,8'h00, 0, 4'd3),  // R3 level low
        mkv(1,0,0,1,8'h33, 1,0,1,1,8'hE0, 0, 4'd4),  // R4 violation
        mkv(1,0,1,0,8'hF7, 0,0,0,0,8'h00, 0, 4'd6),  // R6 first marker
        mkv(1,0,1,0,8'hFB, 0,0,0,0,8'h00, 0, 4'd6),  // R6 replaced
        mkv(1,0,0,0,8'h21, 1,1,1,0,8'h21, 0, 4'd6),  // R6 command tag wins
        mkv(1,0,1,0,8'hF7, 0,0,0,0,8'h00, 0, 4'd3),  // R3 marker then signal
        mkv(1,0,1,0,8'h1C, 0,0,0,0,8'h00, 1, 4'd3),
        mkv(1,0,0,0,8'h22, 1,1,0,0,8'h22, 1, 4'd3),  // R3 tag survived
        mkv(1,0,1,0,8'hF7, 0,0,0,0,8'h00, 1, 4'd4),
        mkv(1,0,0,1,8'h00, 1,0,1,1,8'hE0, 1, 4'd4),  // R4 violation eats tag
        mkv(1,0,0,0,8'h23, 1,0,0,0,8'h23, 1, 4'd4),  // R4 tag gone
        mkv(1,0,1,0,8'hF7, 0,0,0,0,8'h00, 1, 4'd8),
        mkv(0,0,0,0,8'h77, 0,0,0,0,8'h00, 1, 4'd8),  // R8 idle, no write
        mkv(0,0,1,0,8'h7C, 0,0,0,0,8'h00, 1, 4'd8),  // R8 invalid signal code ignored
        mkv(1,0,0,0,8'h24, 1,1,0,0,8'h24, 1, 4'd8),  // R8 tag kept over idle
        mkv(1,0,0,0,8'hF7, 1,0,0,0,8'hF7, 1, 4'd5),  // R5 marker byte as data
        mkv(1,1,1,0,8'hF7, 1,0,1,0,8'hF7, 1, 4'd9),  // R9 marker passed
        mkv(1,1,1,0,8'h7C, 1,0,1,0,8'h7C, 1, 4'd9),  // R9 level holds
        mkv(1,1,0,1,8'h33, 1,0,0,1,8'h33, 1, 4'd9),  // R9 raw violation
        mkv(1,0,1,0,8'hF7, 0,0,0,0,8'h00, 1, 4'd9),
        mkv(1,1,0,0,8'h44, 1,0,0,0,8'h44, 1, 4'd9),  // R9 bypass untagged
        mkv(1,0,0,0,8'h45, 1,0,0,0,8'h45, 1, 4'd9),  // R9 tag dropped
        mkv(1,0,1,0,8'h7C, 0,0,0,0,8'h00, 0, 4'd3),
        mkv(1,0,0,0,8'h50, 1,0,0,0,8'h50, 0, 4'd8),
        mkv(0,0,0,0,8'h50, 0,0,0,0,8'h00, 0, 4'd8)   // R8 single-cycle strobe
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input bit b, input bit c, input bit x, input logic [7:0] d);
        in_valid = v; bypass = b; in_is_ctrl = c; in_viol = x; in_data = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_en_o == 1'b0, "R7", "strobe in reset", int'(wr_en_o), 0);
        chk(sig_o == 1'b0, "R7", "level in reset", int'(sig_o), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [28:0] e;
            string rq;
            e  = VEC[i];
            rq = $sformatf("R%0d", e[3:0]);
            drive(e[28], e[27], e[26], e[25], e[24:17]);
            @(negedge clk);
            chk(wr_en_o == e[16], rq, $sformatf("v%0d strobe", i), int'(wr_en_o), int'(e[16]));
            if (e[16]) begin
                chk(wr_data_o == e[12:5], rq, $sformatf("v%0d data", i), int'(wr_data_o), int'(e[12:5]));
                chk(wr_soc_o == e[15], rq, $sformatf("v%0d soc", i), int'(wr_soc_o), int'(e[15]));
                chk(wr_ctrl_o == e[14], rq, $sformatf("v%0d ctrl", i), int'(wr_ctrl_o), int'(e[14]));
                chk(wr_viol_o == e[13], rq, $sformatf("v%0d viol", i), int'(wr_viol_o), int'(e[13]));
            end
            chk(sig_o == e[4], rq, $sformatf("v%0d level", i), int'(sig_o), int'(e[4]));
        end

        // R7: reset mid-stream clears level and pending tag
        drive(1, 0, 1, 0, 8'h1C);
        @(negedge clk);
        drive(1, 0, 1, 0, 8'hF7);
        @(negedge clk);
        chk(sig_o == 1'b1, "R7", "level before reset", int'(sig_o), 1);
        drive(0, 0, 0, 0, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sig_o == 1'b0, "R7", "level after reset", int'(sig_o), 0);
        chk(wr_en_o == 1'b0, "R7", "strobe after reset", int'(wr_en_o), 0);
        rst_n = 1'b1;
        drive(1, 0, 0, 0, 8'h66);
        @(negedge clk);
        chk(wr_en_o == 1'b1, "R7", "write after reset", int'(wr_en_o), 1);
        chk(wr_soc_o == 1'b0, "R7", "tag cleared by reset", int'(wr_soc_o), 0);

        // R2 then R4: violation on a command marker byte wins over the marker
        drive(1, 0, 1, 1, 8'hFB);
        @(negedge clk);
        chk(wr_en_o == 1'b1 && wr_viol_o == 1'b1, "R4", "violated marker written",
            int'({wr_en_o, wr_viol_o}), 3);
        chk(wr_data_o == 8'hE0, "R4", "violated marker data", int'(wr_data_o), 'hE0);
        drive(0, 0, 0, 0, 8'h00);
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule